// File: doc/BRIEF.md
# RSA Engine Control Registers

This block is the register front end and sequencer of a public-key modular-exponentiation accelerator. Software reaches it through a 32-bit register bus with a valid/ready handshake. Through that bus it loads the command, the DMA source address and length, the packed exponent/modulus bit counts and the interrupt mask. It then writes the trigger register to start a run. A run can include an operand fetch, in which beats arriving on the DMA side are written into a small local data SRAM. The fetch is followed by a compute phase. A placeholder compute unit stands in for the arithmetic and takes a fixed, parameterised number of cycles.

When the compute phase ends, the sequencer parks in a done state and latches a completion flag. If that flag is unmasked, it drives the interrupt line. Software acknowledges by writing the flag back as a one. It stops the engine by writing zero to the trigger register, which also aborts a run that is still in progress. A command bit decides who owns the data SRAM: the CPU through an address window, or the fetch path.

Top module: `pke_ctrl_top`

## Requirements
- R1: After reset every register reads zero except the DMA length register, which reads 0x1800. `irq`, `dmaReq` and `busReady` are low.
- R2: `busReady` rises one cycle after `busValid` is seen high while `busReady` is low, and stays high for exactly one cycle. A transfer happens in the cycle where both are high. `busRdData` is zero outside that cycle. Register addresses that are not mapped read as zero.
- R3: The register word offsets are: trigger 0x000, command 0x048, DMA base 0x04C, DMA length 0x050, key length 0x058, mask 0x3F8, status 0x3FC. The command register keeps only bits 8 and 5:4. The mask register keeps only bit 1. The trigger register reads back its stored bits [1:0]. The key-length register holds the exponent bit count in [31:16] and the modulus bit count in [15:0]. `dmaAddr` and `dmaLen` present the base and length registers.
- R4: In idle, a trigger write with bit 1 set enters the fetch phase, and `dmaReq` is high from the next cycle. A trigger write with only bit 0 set goes straight to compute, and `dmaReq` stays low.
- R5: The fetch phase ends on a DMA beat that has `dmaLast` high. The run then moves to compute if trigger bit 0 is set. Otherwise it returns to idle, and the trigger register clears to 0.
- R6: Compute lasts exactly `ComputeCycles` cycles. The sequencer then enters done and sets status bit 1.
- R7: `irq` is high exactly while status bit 1 and mask bit 1 are both set.
- R8: Status bit 1 is write-one-to-clear. Writing 0 to it has no effect, and a completion in the same cycle as the clear wins.
- R9: Status bit 0 reads 1 while a fetch or compute is in progress. A nonzero trigger write outside idle (fetch, compute or done) is ignored, and the trigger register is unchanged.
- R10: A trigger write whose bits [1:0] are zero returns the sequencer to idle from any state and clears the trigger register. Status bit 1 is left as it was.
- R11: A start is refused, leaving the sequencer idle and the trigger register at 0, when the modulus bit count exceeds `MaxKeyBits` (4096). A count of exactly 4096 is accepted.
- R12: DMA beats are stored at consecutive SRAM words starting from word 0 of each run. They are stored only when command bits [5:4] are 2'b11 and command bit 8 is 0; otherwise they are dropped.
- R13: Addresses with bit 11 set form the CPU SRAM window, and word index = address bits [5:2] by default. A CPU read there returns the stored word, and a CPU write there takes effect, only when command bit 8 is 1 and no fetch or compute is in progress. Otherwise reads return 0 and writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Register bus byte address |
| busWrEn | input | 1 | 1 = write, 0 = read |
| busWrData | input | 32 | Write data |
| busValid | input | 1 | Request valid |
| busReady | output | 1 | One-cycle accept pulse |
| busRdData | output | 32 | Read data, valid with busReady |
| dmaReq | output | 1 | Operand fetch in progress |
| dmaAddr | output | 32 | Fetch source base address |
| dmaLen | output | 32 | Fetch length in bytes |
| dmaValid | input | 1 | Fetch beat valid |
| dmaData | input | 32 | Fetch beat data |
| dmaLast | input | 1 | Final beat of the fetch |
| irq | output | 1 | Completion interrupt |

## Verification
The sequencer is driven through each of its start patterns, and each pattern separates a different path:
- A combined fetch-and-compute start checks the beat storage and the exact compute latency.
- A compute-only start confirms that no fetch request appears.
- A fetch-only start confirms the return to idle with the trigger cleared.
- Starts written mid-run and in done must leave the trigger readback unchanged, which separates "ignored" from "restarted".
- Key lengths of 4097 and 4096 bits pin the limit comparison to its exact boundary.

SRAM ownership is tried in three cases: CPU-owned while idle, CPU-owned while running, and engine-owned while the CPU bit is set. Together these show which side of each gate is broken.

// File: rtl/pke_pkg.sv
package pke_pkg;

  // register word indices (byte offset >> 2); bit 11 of the byte address selects the SRAM window
  localparam logic [9:0] IdxTrig = 10'h000;
  localparam logic [9:0] IdxCmd  = 10'h012;
  localparam logic [9:0] IdxBase = 10'h013;
  localparam logic [9:0] IdxLen  = 10'h014;
  localparam logic [9:0] IdxKey  = 10'h016;
  localparam logic [9:0] IdxMask = 10'h0FE;
  localparam logic [9:0] IdxStat = 10'h0FF;

  localparam logic [31:0] CmdKeepMask = 32'h0000_0130;
  localparam int unsigned CmdCpuOwnBit = 8;

  typedef enum logic [1:0] {
    StIdle    = 2'd0,
    StDma     = 2'd1,
    StCompute = 2'd2,
    StDone    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic       dmaStart;   // a fetch run is accepted this cycle
    logic       dmaActive;  // beats are accepted
    logic       running;    // fetch or compute in progress
    logic       setDone;    // completion this cycle
    logic [1:0] trigVal;    // stored trigger bits
  } ctlStrobe_t;

endpackage

// File: rtl/pke_seq.sv
module pke_seq
  import pke_pkg::*;
#(
  parameter int unsigned ComputeCycles = 24,
  parameter int unsigned MaxKeyBits    = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigWr,
  input  logic [1:0]  trigData,
  input  logic [15:0] modBits,
  input  logic        dmaValid,
  input  logic        dmaLast,
  output logic        dmaReq,
  output ctlStrobe_t  strb
);

  localparam int unsigned CntW = (ComputeCycles > 1) ? $clog2(ComputeCycles) : 1;
  localparam logic [CntW-1:0] CntLoad = CntW'(ComputeCycles - 1);

  seqState_t       state;
  logic [1:0]      trigQ;
  logic [CntW-1:0] cnt;

  logic keyOk, abortReq, startOk, dmaEnd, computeEnd;

  assign keyOk      = 32'(modBits) <= MaxKeyBits;
  assign abortReq   = trigWr && (trigData == 2'b00);
  assign startOk    = trigWr && (trigData != 2'b00) && (state == StIdle) && keyOk;
  assign dmaEnd     = (state == StDma) && dmaValid && dmaLast;
  assign computeEnd = (state == StCompute) && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= StIdle;
      trigQ <= 2'b00;
      cnt   <= '0;
    end else if (abortReq) begin
      state <= StIdle;
      trigQ <= 2'b00;
    end else begin
      case (state)
        StIdle: begin
          if (startOk) begin
            trigQ <= trigData;
            if (trigData[1]) begin
              state <= StDma;
            end else begin
              state <= StCompute;
              cnt   <= CntLoad;
            end
          end
        end
        StDma: begin
          if (dmaEnd) begin
            if (trigQ[0]) begin
              state <= StCompute;
              cnt   <= CntLoad;
            end else begin
              state <= StIdle;
              trigQ <= 2'b00;
            end
          end
        end
        StCompute: begin
          if (cnt == '0) state <= StDone;
          else           cnt   <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign dmaReq         = (state == StDma);
  assign strb.dmaStart  = startOk && trigData[1];
  assign strb.dmaActive = (state == StDma);
  assign strb.running   = (state == StDma) || (state == StCompute);
  assign strb.setDone   = computeEnd && !abortReq;
  assign strb.trigVal   = trigQ;

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && trigData != 2'b00 && state != StIdle && !dmaEnd) |=> $stable(trigQ)); // R9

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (state == StIdle && trigQ == 2'b00)); // R10

  AST_COMPUTE_ENDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (computeEnd && !abortReq) |=> (state == StDone)); // R6

  AST_OVERSIZE_KEY_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && state == StIdle && !keyOk) |=> (state == StIdle)); // R11

endmodule

// File: rtl/pke_regfile.sv
module pke_regfile
  import pke_pkg::*;
#(
  parameter int unsigned SramWords   = 16,
  parameter logic [31:0] DmaLenReset = 32'h0000_1800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  input  logic        busValid,
  output logic        busReady,
  output logic [31:0] busRdData,
  input  logic        dmaValid,
  input  logic [31:0] dmaData,
  output logic [31:0] dmaAddr,
  output logic [31:0] dmaLen,
  output logic        irq,
  input  ctlStrobe_t  strb,
  output logic        trigWr,
  output logic [1:0]  trigData,
  output logic [15:0] modBits
);

  localparam int unsigned SramAw = (SramWords > 1) ? $clog2(SramWords) : 1;

  logic              readyQ;
  logic [31:0]       cmdQ, baseQ, lenQ, keyQ;
  logic              maskQ, doneQ;
  logic [SramAw-1:0] dmaPtr;
  logic [31:0]       sramMem [SramWords];

  logic              wrFire, regWr, isSram, cpuSramOk, beatStore, statClr;
  logic [9:0]        wordIdx;
  logic [SramAw-1:0] sramIdx;
  logic [31:0]       rdMux;

  assign isSram    = busAddr[11];
  assign wordIdx   = busAddr[11:2];
  assign sramIdx   = busAddr[2 +: SramAw];
  assign wrFire    = busValid && readyQ && busWrEn;
  assign regWr     = wrFire && !isSram;
  assign cpuSramOk = cmdQ[CmdCpuOwnBit] && !strb.running;
  assign beatStore = strb.dmaActive && dmaValid && (cmdQ[5:4] == 2'b11) && !cmdQ[CmdCpuOwnBit];
  assign statClr   = regWr && (wordIdx == IdxStat) && busWrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      cmdQ   <= '0;
      baseQ  <= '0;
      lenQ   <= DmaLenReset;
      keyQ   <= '0;
      maskQ  <= 1'b0;
      doneQ  <= 1'b0;
      dmaPtr <= '0;
      for (int i = 0; i < int'(SramWords); i++) sramMem[i] <= '0;
    end else begin
      readyQ <= busValid && !readyQ;
      if (regWr) begin
        case (wordIdx)
          IdxCmd:  cmdQ  <= busWrData & CmdKeepMask;
          IdxBase: baseQ <= busWrData;
          IdxLen:  lenQ  <= busWrData;
          IdxKey:  keyQ  <= busWrData;
          IdxMask: maskQ <= busWrData[1];
          default: ;
        endcase
      end
      if (strb.setDone)  doneQ <= 1'b1;
      else if (statClr)  doneQ <= 1'b0;
      if (strb.dmaStart)                      dmaPtr <= '0;
      else if (strb.dmaActive && dmaValid)    dmaPtr <= dmaPtr + 1'b1;
      if (beatStore)                          sramMem[dmaPtr]  <= dmaData;
      else if (wrFire && isSram && cpuSramOk) sramMem[sramIdx] <= busWrData;
    end
  end

  always_comb begin
    rdMux = '0;
    if (isSram) begin
      if (cpuSramOk) rdMux = sramMem[sramIdx];
    end else begin
      case (wordIdx)
        IdxTrig: rdMux = {30'd0, strb.trigVal};
        IdxCmd:  rdMux = cmdQ;
        IdxBase: rdMux = baseQ;
        IdxLen:  rdMux = lenQ;
        IdxKey:  rdMux = keyQ;
        IdxMask: rdMux = {30'd0, maskQ, 1'b0};
        IdxStat: rdMux = {30'd0, doneQ, strb.running};
        default: rdMux = '0;
      endcase
    end
  end

  assign busReady  = readyQ;
  assign busRdData = readyQ ? rdMux : 32'd0;
  assign dmaAddr   = baseQ;
  assign dmaLen    = lenQ;
  assign irq       = doneQ && maskQ;
  assign trigWr    = regWr && (wordIdx == IdxTrig);
  assign trigData  = busWrData[1:0];
  assign modBits   = keyQ[15:0];

  AST_READY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady); // R2

  AST_DONE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> doneQ); // R8

  AST_PTR_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strb.dmaStart |=> (dmaPtr == '0)); // R12

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !statClr) |=> doneQ); // R8

endmodule

// File: rtl/pke_ctrl_top.sv
module pke_ctrl_top
  import pke_pkg::*;
#(
  parameter int unsigned ComputeCycles = 24,
  parameter int unsigned MaxKeyBits    = 4096,
  parameter int unsigned SramWords     = 16,
  parameter logic [31:0] DmaLenReset   = 32'h0000_1800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  input  logic        busValid,
  output logic        busReady,
  output logic [31:0] busRdData,
  output logic        dmaReq,
  output logic [31:0] dmaAddr,
  output logic [31:0] dmaLen,
  input  logic        dmaValid,
  input  logic [31:0] dmaData,
  input  logic        dmaLast,
  output logic        irq
);

  ctlStrobe_t  strb;
  logic        trigWr;
  logic [1:0]  trigData;
  logic [15:0] modBits;

  pke_seq #(
    .ComputeCycles(ComputeCycles),
    .MaxKeyBits   (MaxKeyBits)
  ) i_seq (
    .clk     (clk),
    .rstN    (rstN),
    .trigWr  (trigWr),
    .trigData(trigData),
    .modBits (modBits),
    .dmaValid(dmaValid),
    .dmaLast (dmaLast),
    .dmaReq  (dmaReq),
    .strb    (strb)
  );

  pke_regfile #(
    .SramWords  (SramWords),
    .DmaLenReset(DmaLenReset)
  ) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busValid (busValid),
    .busReady (busReady),
    .busRdData(busRdData),
    .dmaValid (dmaValid),
    .dmaData  (dmaData),
    .dmaAddr  (dmaAddr),
    .dmaLen   (dmaLen),
    .irq      (irq),
    .strb     (strb),
    .trigWr   (trigWr),
    .trigData (trigData),
    .modBits  (modBits)
  );

endmodule

// File: tb/test_pke_ctrl_top.sv
module test_pke_ctrl_top;

  localparam int ClkPeriod = 10;
  localparam int Lat       = 6;
  localparam int KeyMax    = 4096;

  localparam logic [11:0] AdTrig = 12'h000, AdCmd = 12'h048, AdBase = 12'h04C,
                          AdLen  = 12'h050, AdKey = 12'h058, AdMask = 12'h3F8,
                          AdStat = 12'h3FC, AdSram = 12'h800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busValid = 1'b0;
  logic        busReady;
  logic [31:0] busRdData;
  logic        dmaReq;
  logic [31:0] dmaAddr, dmaLen;
  logic        dmaValid = 1'b0;
  logic [31:0] dmaData = '0;
  logic        dmaLast = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFail   = 0;
  bit doneFlag = 0;

  always #(ClkPeriod/2) clk = ~clk;

  pke_ctrl_top #(.ComputeCycles(Lat), .MaxKeyBits(KeyMax)) i_pke_ctrl_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busValid(busValid), .busReady(busReady), .busRdData(busRdData), .dmaReq(dmaReq),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaValid(dmaValid), .dmaData(dmaData),
    .dmaLast(dmaLast), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int          mState;  // 0 idle, 1 fetch, 2 compute, 3 done
  logic [1:0]  mTrig;
  int          mCnt;
  logic [31:0] mCmd, mBase, mLen, mKey;
  logic        mMask, mDone, mRdy;
  int          mPtr;
  logic [31:0] mSram [16];

  task automatic modelReset();
    mState = 0; mTrig = 0; mCnt = 0; mCmd = 0; mBase = 0; mLen = 32'h1800; mKey = 0;
    mMask = 0; mDone = 0; mRdy = 0; mPtr = 0;
    for (int i = 0; i < 16; i++) mSram[i] = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      automatic bit fire    = busValid && mRdy;
      automatic bit wr      = fire && busWrEn;
      automatic bit regW    = wr && !busAddr[11];
      automatic int idx     = int'(busAddr[11:2]);
      automatic int st      = mState;
      automatic bit running = (st == 1) || (st == 2);
      automatic bit trigW   = regW && idx == 0;
      automatic bit setD    = 0;
      if (st == 1 && dmaValid) begin
        if (mCmd[5:4] == 2'b11 && !mCmd[8]) mSram[mPtr] = dmaData;
        mPtr = (mPtr + 1) % 16;
      end
      if (wr && busAddr[11] && mCmd[8] && !running) mSram[busAddr[5:2]] = busWrData;
      if (trigW && busWrData[1:0] == 2'b00) begin
        mState = 0; mTrig = 0;
      end else begin
        case (st)
          0: if (trigW && int'(mKey[15:0]) <= KeyMax) begin
               mTrig = busWrData[1:0];
               if (busWrData[1]) begin mState = 1; mPtr = 0; end
               else begin mState = 2; mCnt = Lat - 1; end
             end
          1: if (dmaValid && dmaLast) begin
               if (mTrig[0]) begin mState = 2; mCnt = Lat - 1; end
               else begin mState = 0; mTrig = 0; end
             end
          2: if (mCnt == 0) begin mState = 3; setD = 1; end else mCnt = mCnt - 1;
          default: ;
        endcase
      end
      if (regW) begin
        case (idx)
          'h12: mCmd  = busWrData & 32'h130;
          'h13: mBase = busWrData;
          'h14: mLen  = busWrData;
          'h16: mKey  = busWrData;
          'hFE: mMask = busWrData[1];
          'hFF: if (busWrData[1]) mDone = 0;
          default: ;
        endcase
      end
      if (setD) mDone = 1;
      mRdy = busValid && !mRdy;
    end
  end

  function automatic logic [31:0] modelRead();
    automatic bit running = (mState == 1) || (mState == 2);
    if (!mRdy) return 32'd0;
    if (busAddr[11]) return (mCmd[8] && !running) ? mSram[busAddr[5:2]] : 32'd0;
    case (int'(busAddr[11:2]))
      'h00: return {30'd0, mTrig};
      'h12: return mCmd;
      'h13: return mBase;
      'h14: return mLen;
      'h16: return mKey;
      'hFE: return {30'd0, mMask, 1'b0};
      'hFF: return {30'd0, mDone, running};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      chk("R2", "busReady vs model", {31'd0, busReady}, {31'd0, mRdy});
      chk("R2", "busRdData vs model", busRdData, modelRead());
      chk("R7", "irq vs model", {31'd0, irq}, {31'd0, mDone && mMask});
      chk("R4", "dmaReq vs model", {31'd0, dmaReq}, {31'd0, mState == 1});
      chk("R3", "dmaAddr vs model", dmaAddr, mBase);
      chk("R3", "dmaLen vs model", dmaLen, mLen);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic busXfer(input logic [11:0] a, input logic we, input logic [31:0] d, output logic [31:0] rd);
    @(posedge clk); #1;
    busValid = 1'b1; busAddr = a; busWrEn = we; busWrData = d;
    do @(negedge clk); while (!busReady);
    rd = busRdData;
    @(posedge clk); #1;
    busValid = 1'b0; busWrEn = 1'b0;
  endtask

  task automatic cpuWr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    busXfer(a, 1'b1, d, dummy);
  endtask

  task automatic cpuRdChk(input logic [11:0] a, input logic [31:0] exp, input string req, input string what);
    logic [31:0] rd;
    busXfer(a, 1'b0, 32'd0, rd);
    chk(req, what, rd, exp);
  endtask

  task automatic sendBeats(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      dmaValid = 1'b1; dmaData = base + 32'(i); dmaLast = (i == n - 1);
    end
    @(posedge clk); #1;
    dmaValid = 1'b0; dmaLast = 1'b0;
  endtask

  task automatic finishRun();
    doneFlag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    chk("R1", "dmaReq after reset", {31'd0, dmaReq}, 32'd0);
    chk("R1", "busReady after reset", {31'd0, busReady}, 32'd0);
    cpuRdChk(AdLen, 32'h1800, "R1", "dma length reset");
    cpuRdChk(AdStat, 32'd0, "R1", "status reset");
    cpuRdChk(AdTrig, 32'd0, "R1", "trigger reset");
    cpuRdChk(AdCmd, 32'd0, "R1", "command reset");

    // R3 register storage and masking
    cpuWr(AdCmd, 32'hFFFF_FFFF);
    cpuRdChk(AdCmd, 32'h130, "R3", "command keeps bits 8,5:4");
    cpuWr(AdMask, 32'hFFFF_FFFF);
    cpuRdChk(AdMask, 32'h2, "R3", "mask keeps bit 1");
    cpuWr(AdBase, 32'h8000_1000);
    cpuRdChk(AdBase, 32'h8000_1000, "R3", "dma base readback");
    chk("R3", "dmaAddr output", dmaAddr, 32'h8000_1000);
    cpuWr(AdKey, {16'd17, 16'd2048});
    cpuRdChk(AdKey, 32'h0011_0800, "R3", "key length fields");
    cpuRdChk(12'h004, 32'd0, "R2", "unmapped read");

    // R13 CPU-owned SRAM while idle
    cpuWr(AdCmd, 32'h100);
    cpuWr(AdSram, 32'h1111_0000);
    cpuWr(AdSram + 12'h4, 32'h2222_0000);
    cpuRdChk(AdSram + 12'h4, 32'h2222_0000, "R13", "cpu sram readback idle");

    // R12 beats dropped when the CPU owns the SRAM; R5 fetch-only run returns idle
    cpuWr(AdCmd, 32'h130);
    cpuWr(AdTrig, 32'h2);
    sendBeats(2, 32'hA0);
    cpuRdChk(AdTrig, 32'd0, "R5", "trigger cleared after fetch-only run");
    cpuRdChk(AdStat, 32'd0, "R5", "idle and no done after fetch-only run");
    cpuRdChk(AdSram, 32'h1111_0000, "R12", "beats dropped while cpu owns sram");

    // R4/R6/R7/R9 full run
    cpuWr(AdCmd, 32'h30);
    cpuWr(AdTrig, 32'h3);
    @(negedge clk);
    chk("R4", "dmaReq after fetch start", {31'd0, dmaReq}, 32'd1);
    cpuRdChk(AdStat, 32'h1, "R9", "busy during fetch");
    sendBeats(4, 32'h1000);
    repeat (Lat) begin
      @(negedge clk);
      chk("R6", "irq low during compute", {31'd0, irq}, 32'd0);
    end
    @(negedge clk);
    chk("R6", "irq high after compute latency", {31'd0, irq}, 32'd1);
    cpuRdChk(AdStat, 32'h2, "R6", "status done, not busy");
    cpuWr(AdTrig, 32'h1);
    cpuRdChk(AdTrig, 32'h3, "R9", "start ignored in done");

    // R8 write-one-to-clear
    cpuWr(AdStat, 32'h0);
    cpuRdChk(AdStat, 32'h2, "R8", "writing zero keeps done");
    cpuWr(AdStat, 32'h2);
    cpuRdChk(AdStat, 32'h0, "R8", "writing one clears done");
    chk("R7", "irq low after clear", {31'd0, irq}, 32'd0);

    // R10 stop; R12 beats stored from word 0
    cpuWr(AdTrig, 32'h0);
    cpuRdChk(AdTrig, 32'h0, "R10", "trigger zero after stop");
    cpuWr(AdCmd, 32'h100);
    cpuRdChk(AdSram, 32'h1000, "R12", "first beat in word 0");
    cpuRdChk(AdSram + 12'hC, 32'h1003, "R12", "fourth beat in word 3");

    // R4 compute-only, R9 start ignored mid-compute, R7 masked interrupt
    cpuWr(AdMask, 32'h0);
    cpuWr(AdTrig, 32'h1);
    @(negedge clk);
    chk("R4", "no dmaReq on compute-only start", {31'd0, dmaReq}, 32'd0);
    cpuWr(AdTrig, 32'h2);
    cpuRdChk(AdTrig, 32'h1, "R9", "start ignored during compute");
    repeat (10) @(posedge clk);
    cpuRdChk(AdStat, 32'h2, "R6", "done after compute-only run");
    chk("R7", "irq masked", {31'd0, irq}, 32'd0);
    cpuWr(AdMask, 32'h2);
    @(negedge clk);
    chk("R7", "irq after unmask", {31'd0, irq}, 32'd1);
    cpuWr(AdTrig, 32'h0);
    cpuRdChk(AdStat, 32'h2, "R10", "stop leaves done flag");
    cpuWr(AdStat, 32'h2);

    // R11 key length boundary
    cpuWr(AdKey, {16'd3, 16'd4097});
    cpuWr(AdTrig, 32'h1);
    cpuRdChk(AdTrig, 32'h0, "R11", "4097-bit modulus refused");
    cpuRdChk(AdStat, 32'h0, "R11", "idle after refused start");
    cpuWr(AdKey, {16'd3, 16'd4096});
    cpuWr(AdTrig, 32'h1);
    cpuRdChk(AdTrig, 32'h1, "R11", "4096-bit modulus accepted");
    cpuWr(AdTrig, 32'h0);

    // R13 CPU access blocked while running; R10 abort of a fetch
    cpuWr(AdCmd, 32'h130);
    cpuWr(AdTrig, 32'h2);
    cpuRdChk(AdSram, 32'h0, "R13", "cpu sram read zero while running");
    cpuWr(AdSram + 12'h14, 32'hDEAD_BEEF);
    cpuWr(AdTrig, 32'h0);
    @(negedge clk);
    chk("R10", "dmaReq low after abort", {31'd0, dmaReq}, 32'd0);
    cpuRdChk(AdStat, 32'h0, "R10", "not busy after abort");
    cpuRdChk(AdSram, 32'h1000, "R13", "cpu sram readable again");
    cpuRdChk(AdSram + 12'h14, 32'h0, "R13", "cpu write while running dropped");

    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule